// File: doc/BRIEF.md
# Command-Queue Register Front End for a Serial Peripheral Controller

This block is the software-facing side of an SPI controller whose bit engine runs from queued commands. A processor reaches it through a plain 32-bit register bus with one-cycle read latency. Writes to two push offsets load a command queue and an outgoing-data queue. Reads of a pop offset drain an incoming-data queue, and a second offset reads the head of that queue without removing it. Status offsets report the free slots in each outbound queue and the fill of the inbound queue.

The bit engine is modelled only through its queue ports. The command and outgoing-data queues leave the block as valid/ready streams. A word is offered while `*_valid` is high. It stays stable until the engine raises `*_ready` in the same cycle, and an empty queue drops `*_valid`. Incoming data enters through a valid/ready stream. `rx_ready` falls when the queue is full, and the engine must then hold its word. The engine also reports a sync marker with an 8-bit tag. The tag is captured and a sticky event bit is set. Three threshold flags are recomputed every cycle from the queue fills. Together with the sync bit they form a 4-bit condition vector. A mask selects which of these bits drive a single level interrupt. A soft-hold bit keeps the engine in reset and flushes and freezes all three queues.

Top module: `xfer_ctrl_front`

## Requirements
- R1: After `rst_n` is released, all queues are empty, command room and outgoing room read 16, incoming level reads 0, the enable mask reads 0, `irq` is low and `engine_rst` is low.
- R2: The register offsets are as follows. Soft hold is at 0x40, enable mask at 0x80, condition vector at 0x84 and masked vector at 0x88. The sync tag is at 0xC0. The room and level counters are at 0xD0 (command room), 0xD4 (outgoing room) and 0xD8 (incoming level). Command push is at 0xE0, outgoing push at 0xE4, incoming pop at 0xE8 and incoming peek at 0xEC. Reads of any other offset return 0.
- R3: Each room register reads 16 minus the number of entries stored. A bus push into a full queue is dropped and changes neither the count nor the stored words.
- R4: The command and outgoing queues deliver words in push order. Each head word is held stable on its stream while `*_valid` is high and `*_ready` is low.
- R5: Condition bit 0 (command queue) and condition bit 1 (outgoing queue) are 1 exactly when that queue holds 4 or fewer words.
- R6: Condition bit 2 is 1 exactly when the incoming queue holds 12 or more words. `rx_ready` is low while that queue holds 16 words, and a word offered then is not stored.
- R7: A read of 0xE8 returns the oldest incoming word and removes it. When the incoming queue is empty, the read returns 0 and the level stays 0.
- R8: A read of 0xEC returns the oldest incoming word and leaves the level unchanged. When the queue is empty, it returns 0.
- R9: A `sync_valid` pulse sets condition bit 3 and stores `sync_id`, which is then read at 0xC0. If a clear of bit 3 arrives in the same cycle, the set wins.
- R10: Writing the condition vector clears bit 3 where the written bit 3 is 1. Written zeros, and writes to bits 0 to 2, have no effect. Writing 0xFF leaves only the live threshold flags.
- R11: `irq` is the OR of the condition vector ANDed with the enable mask (bits 3:0). Offset 0x88 reads that AND.
- R12: Bit 0 of 0x40 set to 1 raises `engine_rst`. While it is set, all queues read empty, bus pushes and stream offers are ignored, and `cmd_valid`, `tx_valid` and `rx_ready` are low. Writing 0 releases the hold and leaves the queues empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cmd_valid | output | 1 | Command word offered to the engine |
| cmd_ready | input | 1 | Engine takes the command word |
| cmd_data | output | 32 | Head command word |
| tx_valid | output | 1 | Outgoing word offered to the engine |
| tx_ready | input | 1 | Engine takes the outgoing word |
| tx_data | output | 32 | Head outgoing word |
| rx_valid | input | 1 | Engine offers an incoming word |
| rx_ready | output | 1 | Incoming queue can store a word |
| rx_data | input | 32 | Incoming word |
| sync_valid | input | 1 | Sync marker pulse from the engine |
| sync_id | input | 8 | Tag carried by the sync marker |
| engine_rst | output | 1 | Holds the engine in reset |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills each queue one word at a time, past its capacity. After each push it compares the room or level and the threshold flag against values computed from the push count. A design that used the wrong compare would show the flag flip one word early or late. A design without a full guard would wrap its pointers and report a room past 16. Draining checks the word order, and an off-by-one pointer would return a shifted sequence. The bench also checks the rarer edges: a pop or peek of an empty incoming queue must return zero, not a stale word, and a sync marker that lands in the same cycle as its own clear must stay pending. It also checks that a queue filled before a soft hold comes back empty and refuses pushes made during the hold.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_HOLD   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_ENA    = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_COND   = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_TAG    = 8'hC0;
  localparam logic [ADDR_W-1:0] OFS_CROOM  = 8'hD0;
  localparam logic [ADDR_W-1:0] OFS_TROOM  = 8'hD4;
  localparam logic [ADDR_W-1:0] OFS_RLVL   = 8'hD8;
  localparam logic [ADDR_W-1:0] OFS_CPUSH  = 8'hE0;
  localparam logic [ADDR_W-1:0] OFS_TPUSH  = 8'hE4;
  localparam logic [ADDR_W-1:0] OFS_RPOP   = 8'hE8;
  localparam logic [ADDR_W-1:0] OFS_RPEEK  = 8'hEC;

  localparam int NCOND     = 4;
  localparam int BIT_CLOW  = 0;
  localparam int BIT_TLOW  = 1;
  localparam int BIT_RHIGH = 2;
  localparam int BIT_SYNC  = 3;

  typedef logic [NCOND-1:0] cond_t;
endpackage

// File: rtl/xfc_fifo.sv
module xfc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != FULL_CNT) && !flush;
  assign do_pop  = pop && (count != '0) && !flush;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/xfc_irq.sv
module xfc_irq
  import xfc_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LOW_TH  = 4,
  parameter int HIGH_TH = 12,
  parameter int ID_W    = 8,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cmd_cnt,
  input  logic [CW-1:0]   tx_cnt,
  input  logic [CW-1:0]   rx_cnt,
  input  logic            sync_evt,
  input  logic [ID_W-1:0] sync_tag,
  input  logic            clr_wr,
  input  logic            clr_bit,
  input  cond_t           ena,
  output cond_t           cond,
  output logic [ID_W-1:0] tag_q,
  output logic            irq
);
  localparam logic [CW-1:0] LOW_C  = CW'(LOW_TH);
  localparam logic [CW-1:0] HIGH_C = CW'(HIGH_TH);

  logic sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      tag_q  <= '0;
    end else if (sync_evt) begin
      sync_q <= 1'b1;
      tag_q  <= sync_tag;
    end else if (clr_wr && clr_bit) begin
      sync_q <= 1'b0;
    end
  end

  always_comb begin
    cond            = '0;
    cond[BIT_CLOW]  = (cmd_cnt <= LOW_C);
    cond[BIT_TLOW]  = (tx_cnt <= LOW_C);
    cond[BIT_RHIGH] = (rx_cnt >= HIGH_C);
    cond[BIT_SYNC]  = sync_q;
  end

  assign irq = |(cond & ena);
endmodule

// File: rtl/xfer_ctrl_front.sv
module xfer_ctrl_front
  import xfc_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LOW_TH  = 4,
  parameter int HIGH_TH = 12,
  parameter int ID_W    = 8,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BUS_W-1:0]  cmd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BUS_W-1:0]  tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BUS_W-1:0]  rx_data,
  input  logic              sync_valid,
  input  logic [ID_W-1:0]   sync_id,
  output logic              engine_rst,
  output logic              irq
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          hold_q;
  cond_t         ena_q;
  cond_t         cond;
  logic [ID_W-1:0] tag_q;
  logic [CW-1:0] cmd_cnt, tx_cnt, rx_cnt;
  logic [BUS_W-1:0] rx_head, rx_view;
  logic          wr_hold, wr_ena, wr_cond, wr_cpush, wr_tpush, rd_pop;

  assign wr_hold  = bus_wr && (bus_addr == OFS_HOLD);
  assign wr_ena   = bus_wr && (bus_addr == OFS_ENA);
  assign wr_cond  = bus_wr && (bus_addr == OFS_COND);
  assign wr_cpush = bus_wr && (bus_addr == OFS_CPUSH);
  assign wr_tpush = bus_wr && (bus_addr == OFS_TPUSH);
  assign rd_pop   = bus_rd && (bus_addr == OFS_RPOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      ena_q  <= '0;
    end else begin
      if (wr_hold) hold_q <= bus_wdata[0];
      if (wr_ena)  ena_q  <= bus_wdata[NCOND-1:0];
    end
  end

  assign engine_rst = hold_q;
  assign cmd_valid  = !hold_q && (cmd_cnt != '0);
  assign tx_valid   = !hold_q && (tx_cnt != '0);
  assign rx_ready   = !hold_q && (rx_cnt != FULL_CNT);

  xfc_fifo #(.W(BUS_W), .DEPTH(DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(hold_q),
    .push(wr_cpush), .din(bus_wdata),
    .pop(cmd_valid && cmd_ready), .head(cmd_data), .count(cmd_cnt)
  );

  xfc_fifo #(.W(BUS_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(hold_q),
    .push(wr_tpush), .din(bus_wdata),
    .pop(tx_valid && tx_ready), .head(tx_data), .count(tx_cnt)
  );

  xfc_fifo #(.W(BUS_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(hold_q),
    .push(rx_valid && rx_ready), .din(rx_data),
    .pop(rd_pop), .head(rx_head), .count(rx_cnt)
  );

  assign rx_view = (rx_cnt != '0) ? rx_head : '0;

  xfc_irq #(
    .DEPTH(DEPTH), .LOW_TH(LOW_TH), .HIGH_TH(HIGH_TH), .ID_W(ID_W)
  ) u_irq (
    .clk(clk), .rst_n(rst_n),
    .cmd_cnt(cmd_cnt), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .sync_evt(sync_valid), .sync_tag(sync_id),
    .clr_wr(wr_cond), .clr_bit(bus_wdata[BIT_SYNC]),
    .ena(ena_q), .cond(cond), .tag_q(tag_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_HOLD:   bus_rdata <= BUS_W'(hold_q);
        OFS_ENA:    bus_rdata <= BUS_W'(ena_q);
        OFS_COND:   bus_rdata <= BUS_W'(cond);
        OFS_MASKED: bus_rdata <= BUS_W'(cond & ena_q);
        OFS_TAG:    bus_rdata <= BUS_W'(tag_q);
        OFS_CROOM:  bus_rdata <= BUS_W'(FULL_CNT - cmd_cnt);
        OFS_TROOM:  bus_rdata <= BUS_W'(FULL_CNT - tx_cnt);
        OFS_RLVL:   bus_rdata <= BUS_W'(rx_cnt);
        OFS_RPOP,
        OFS_RPEEK:  bus_rdata <= rx_view;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xfc_checks.sv
module xfc_checks
  import xfc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [BUS_W-1:0]  cmd_data,
  input logic              tx_valid,
  input logic              rx_ready,
  input logic              sync_valid,
  input logic              engine_rst,
  input logic              irq,
  input logic [CW-1:0]     cmd_cnt,
  input logic [CW-1:0]     rx_cnt,
  input cond_t             ena_q
);
  assert_enter_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_HOLD && bus_wdata[0]) |=> engine_rst);

  assert_hold_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |-> (!cmd_valid && !tx_valid && !rx_ready));

  assert_head_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !(bus_wr && bus_addr == OFS_HOLD))
      |=> (cmd_valid && $stable(cmd_data)));

  assert_sync_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && ena_q[BIT_SYNC] && !(bus_wr && bus_addr == OFS_ENA)) |=> irq);

  assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(DEPTH)) |-> !rx_ready);

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_RPOP && rx_cnt == '0) |=> (bus_rdata == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cnt <= CW'(DEPTH));
endmodule

bind xfer_ctrl_front xfc_checks #(.DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .tx_valid(tx_valid), .rx_ready(rx_ready), .sync_valid(sync_valid),
  .engine_rst(engine_rst), .irq(irq), .cmd_cnt(cmd_cnt), .rx_cnt(rx_cnt),
  .ena_q(ena_q)
);

// File: tb/tb_xfer_ctrl_front.sv
module tb_xfer_ctrl_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_id = '0;
  logic        engine_rst, irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xfer_ctrl_front dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 offsets, R5 flags on empty queues
    rd(8'hD0, v); chk("R1 cmd room", v, 16);
    rd(8'hD4, v); chk("R1 tx room", v, 16);
    rd(8'hD8, v); chk("R1 rx level", v, 0);
    rd(8'h80, v); chk("R1 enable", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 engine_rst", engine_rst, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    rd(8'h84, v); chk("R5 cond empty", v, 32'h3);
    rd(8'h9C, v); chk("R2 unmapped", v, 0);

    // R3/R5 command queue sweep past full
    for (int k = 1; k <= 18; k++) begin
      int used;
      used = (k > 16) ? 16 : k;
      wr(8'hE0, 32'd100 + k);
      rd(8'hD0, v); chk("R3 cmd room", v, 16 - used);
      rd(8'h84, v); chk("R5 cmd low flag", v[0], (used <= 4));
    end
    // R4 order and hold
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      chk("R4 cmd valid", cmd_valid, 1);
      chk("R4 cmd order", cmd_data, 32'd100 + i);
      @(negedge clk);
      chk("R4 cmd held", cmd_data, 32'd100 + i);
      cmd_ready = 1'b1;
      @(negedge clk); cmd_ready = 1'b0;
    end
    chk("R4 cmd drained", cmd_valid, 0);

    // R3/R5 outgoing queue sweep
    for (int k = 1; k <= 17; k++) begin
      int used;
      used = (k > 16) ? 16 : k;
      wr(8'hE4, 32'd200 + k);
      rd(8'hD4, v); chk("R3 tx room", v, 16 - used);
      rd(8'h84, v); chk("R5 tx low flag", v[1], (used <= 4));
    end
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      chk("R4 tx order", tx_data, 32'd200 + i);
      tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
    end
    chk("R4 tx drained", tx_valid, 0);

    // R6 incoming queue fill
    for (int k = 1; k <= 17; k++) begin
      int used;
      used = (k > 16) ? 16 : k;
      @(negedge clk);
      chk("R6 rx_ready", rx_ready, (k <= 16));
      rx_valid = 1'b1; rx_data = 32'd300 + k;
      @(negedge clk); rx_valid = 1'b0;
      rd(8'hD8, v); chk("R6 rx level", v, used);
      rd(8'h84, v); chk("R6 rx high flag", v[2], (used >= 12));
    end
    // R8 peek
    rd(8'hEC, v); chk("R8 peek", v, 301);
    rd(8'hEC, v); chk("R8 peek again", v, 301);
    rd(8'hD8, v); chk("R8 level kept", v, 16);
    // R7 pop
    for (int i = 1; i <= 16; i++) begin
      rd(8'hE8, v); chk("R7 pop order", v, 32'd300 + i);
    end
    rd(8'hE8, v); chk("R7 empty pop", v, 0);
    rd(8'hD8, v); chk("R7 level zero", v, 0);
    rd(8'hEC, v); chk("R8 empty peek", v, 0);

    // R9/R10/R11 sync handling
    wr(8'h80, 32'h8);
    @(negedge clk); sync_valid = 1'b1; sync_id = 8'hA5;
    @(negedge clk); sync_valid = 1'b0;
    chk("R11 irq on sync", irq, 1);
    rd(8'hC0, v); chk("R9 tag", v, 32'hA5);
    rd(8'h84, v); chk("R9 cond sync", v, 32'hB);
    rd(8'h88, v); chk("R11 masked", v, 32'h8);
    wr(8'h84, 32'h0);
    rd(8'h84, v); chk("R10 zero write", v, 32'hB);
    wr(8'h84, 32'h8);
    rd(8'h84, v); chk("R10 clear", v, 32'h3);
    chk("R11 irq cleared", irq, 0);
    @(negedge clk);
    sync_valid = 1'b1; sync_id = 8'h3C;
    bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'hFF;
    @(negedge clk); sync_valid = 1'b0; bus_wr = 1'b0;
    rd(8'h84, v); chk("R9 set wins", v, 32'hB);
    rd(8'hC0, v); chk("R9 new tag", v, 32'h3C);
    wr(8'h84, 32'hFF);
    rd(8'h84, v); chk("R10 clear all", v, 32'h3);

    // R11 threshold-driven interrupt
    wr(8'h80, 32'h1);
    chk("R11 irq low cmd", irq, 1);
    rd(8'h88, v); chk("R11 masked low", v, 32'h1);
    for (int k = 1; k <= 5; k++) wr(8'hE0, 32'd500 + k);
    chk("R11 irq drops", irq, 0);
    wr(8'h80, 32'h0);

    // R12 soft hold
    wr(8'h40, 32'h1);
    chk("R12 engine_rst", engine_rst, 1);
    chk("R12 cmd_valid off", cmd_valid, 0);
    chk("R12 rx_ready off", rx_ready, 0);
    rd(8'hD0, v); chk("R12 flushed", v, 16);
    wr(8'hE0, 32'hDEAD);
    rd(8'hD0, v); chk("R12 push ignored", v, 16);
    rd(8'h40, v); chk("R12 hold read", v, 1);
    wr(8'h40, 32'h0);
    chk("R12 released", engine_rst, 0);
    rd(8'hD0, v); chk("R12 empty after", v, 16);
    chk("R12 no stale cmd", cmd_valid, 0);

    finish_run();
  end
endmodule